// File: doc/BRIEF.md
# PWM Fault Protection Controller

This block sits between a PWM counter and the channel pins. It watches one external fault input. When that input shows an active edge, the block forces every channel output to a programmed safe level and latches a sticky fault flag. The flag can raise an interrupt. The counter is outside the block. It supplies the raw channel levels and a one-cycle pulse at the start of each PWM period.

Software reaches the block through a small register port with three registers. CONFIG (address 0) holds the fault mode and the interrupt enable. STATUS (address 1) holds the fault flag and the synchronized pin level. SAFE (address 2) holds the per-channel safe levels.

Clearing the flag takes two steps: software reads STATUS while the flag is set, then writes a zero to the flag bit. Masked outputs come back only at a period start. In manual mode that start must follow a cleared flag. In automatic mode it must find the fault pin inactive.

Top module: `pwmflt_top`

## Requirements
- R1: CONFIG (address 0) holds the mode in bits [1:0] and the interrupt enable in bit 2. Mode 00 is off, 01 and 10 are manual clearing, and 11 is automatic clearing. SAFE (address 2) bits [NCH-1:0] give each channel's masked level. A read returns the register on the cycle after `reg_rd_i`.
- R2: Only an inactive-to-active change of the synchronized fault pin counts as a fault. A pin held active after the flag is cleared does not set the flag again.
- R3: In a mode other than 00, a fault sets the sticky flag (STATUS bit 0) and drives `pwm_o` to the SAFE value. Both take effect within four clock cycles of the pin change.
- R4: `irq_o` is high exactly while the flag is set and the interrupt enable is 1, one cycle behind either of them.
- R5: A write of 0 to STATUS bit 0 clears the flag only if a STATUS read was made while the flag was set, after the last fault. A zero write without such a read leaves the flag set.
- R6: STATUS bit 1 reads the present level of the fault pin after the two-flop synchronizer.
- R7: In manual mode, masked outputs stay masked through every period start while the flag is set. They return to the raw levels at the first period start after the flag is cleared.
- R8: In automatic mode, masked outputs return to the raw levels at the first period start that finds the synchronized pin inactive, whatever the flag holds. A period start with the pin still active keeps them masked.
- R9: If a fault is detected between the arming STATUS read and the zero write, the flag stays set. A fresh read is then needed before a zero write can clear it.
- R10: In mode 00, faults neither set the flag nor mask the outputs. `pwm_o` follows `pwm_raw_i` one cycle later.
- R11: After reset the flag, the interrupt enable, the mode, SAFE and `irq_o` are 0, and the outputs follow the raw inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_pin_i | input | 1 | Asynchronous external fault input |
| cycle_start_i | input | 1 | One-cycle pulse at the start of each PWM period |
| pwm_raw_i | input | NCH | Channel levels from the PWM counter |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, registered |
| pwm_o | output | NCH | Protected channel outputs, registered |
| irq_o | output | 1 | Fault interrupt request |

## Verification
The bench builds the block with four channels, an active-high fault pin and a two-stage synchronizer. These values make the register data width four bits, so the SAFE pattern 1010 and the raw patterns can be told apart on every channel. The short synchronizer keeps the edge-to-mask latency small enough to place the read and the zero write on either side of a second fault edge. It also lets a period start fall before or after the pin has settled inactive.

// File: rtl/pwmflt_pkg.sv
package pwmflt_pkg;

  typedef enum logic [1:0] {
    FM_OFF   = 2'b00,
    FM_MAN_A = 2'b01,
    FM_MAN_B = 2'b10,
    FM_AUTO  = 2'b11
  } fmode_e;

  localparam logic [1:0] RA_CFG  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_SAFE = 2'd2;

  function automatic logic mode_is_manual(fmode_e m);
    return (m == FM_MAN_A) || (m == FM_MAN_B);
  endfunction

endpackage

// File: rtl/pwmflt_insync.sv
module pwmflt_insync #(
  parameter int STAGES      = 2,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              pin_act;

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign pin_act = pin_i;
    end else begin : g_lo
      assign pin_act = ~pin_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_act};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pwmflt_regs.sv
module pwmflt_regs
  import pwmflt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [1:0]     addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           flag_i,
  input  logic           level_i,
  output logic [DW-1:0]  rdata_o,
  output fmode_e         mode_o,
  output logic           irq_en_o,
  output logic [NCH-1:0] safe_o,
  output logic           stat_rd_o,
  output logic           stat_zero_o,
  output logic           cfg_wr_o
);
  fmode_e         mode_q;
  logic           irq_en_q;
  logic [NCH-1:0] safe_q;
  logic [DW-1:0]  rdata_q;
  logic [DW-1:0]  rd_val;

  assign cfg_wr_o    = wr_i && (addr_i == RA_CFG);
  assign stat_rd_o   = rd_i && (addr_i == RA_STAT);
  assign stat_zero_o = wr_i && (addr_i == RA_STAT) && !wdata_i[0];

  always_comb begin
    rd_val = '0;
    unique case (addr_i)
      RA_CFG:  begin
        rd_val[1:0] = mode_q;
        rd_val[2]   = irq_en_q;
      end
      RA_STAT: begin
        rd_val[0] = flag_i;
        rd_val[1] = level_i;
      end
      RA_SAFE: rd_val[NCH-1:0] = safe_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= FM_OFF;
      irq_en_q <= 1'b0;
      safe_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (cfg_wr_o) begin
        mode_q   <= fmode_e'(wdata_i[1:0]);
        irq_en_q <= wdata_i[2];
      end
      if (wr_i && (addr_i == RA_SAFE)) safe_q <= wdata_i[NCH-1:0];
      if (rd_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o  = rdata_q;
  assign mode_o   = mode_q;
  assign irq_en_o = irq_en_q;
  assign safe_o   = safe_q;
endmodule

// File: rtl/pwmflt_flag.sv
module pwmflt_flag
  import pwmflt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  fmode_e mode_i,
  input  logic   edge_i,
  input  logic   stat_rd_i,
  input  logic   stat_zero_i,
  input  logic   irq_en_i,
  output logic   flag_o,
  output logic   armed_o,
  output logic   irq_o
);
  logic flag_q, armed_q, irq_q;
  logic set_ev, clr_ev;

  assign set_ev = edge_i && (mode_i != FM_OFF);
  assign clr_ev = stat_zero_i && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;

      if (set_ev || clr_ev || !flag_q) armed_q <= 1'b0;
      else if (stat_rd_i)              armed_q <= 1'b1;

      irq_q <= flag_q && irq_en_i;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pwmflt_mask.sv
module pwmflt_mask
  import pwmflt_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  fmode_e         mode_i,
  input  logic           edge_i,
  input  logic           level_i,
  input  logic           flag_i,
  input  logic           start_i,
  input  logic [NCH-1:0] raw_i,
  input  logic [NCH-1:0] safe_i,
  output logic           mask_o,
  output logic [NCH-1:0] pwm_o
);
  logic           mask_q;
  logic           release_ok;
  logic [NCH-1:0] pwm_q;

  always_comb begin
    if (mode_i == FM_AUTO)          release_ok = !level_i;
    else if (mode_is_manual(mode_i)) release_ok = !flag_i;
    else                            release_ok = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
    end else if (mode_i == FM_OFF) begin
      mask_q <= 1'b0;
    end else if (edge_i) begin
      mask_q <= 1'b1;
    end else if (mask_q && start_i && release_ok) begin
      mask_q <= 1'b0;
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      always_ff @(posedge clk) begin
        if (rst) pwm_q[ch] <= 1'b0;
        else     pwm_q[ch] <= (mask_q && mode_i != FM_OFF) ? safe_i[ch] : raw_i[ch];
      end
    end
  endgenerate

  assign mask_o = mask_q;
  assign pwm_o  = pwm_q;
endmodule

// File: rtl/pwmflt_top.sv
module pwmflt_top
  import pwmflt_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_HIGH = 1'b1,
  parameter int DW          = (NCH > 3) ? NCH : 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fault_pin_i,
  input  logic           cycle_start_i,
  input  logic [NCH-1:0] pwm_raw_i,
  input  logic           reg_rd_i,
  input  logic           reg_wr_i,
  input  logic [1:0]     reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic [NCH-1:0] pwm_o,
  output logic           irq_o
);
  logic           pin_lvl, pin_edge;
  fmode_e         mode_q;
  logic           irq_en_q;
  logic [NCH-1:0] safe_q;
  logic           stat_rd, stat_zero, cfg_wr;
  logic           flag_q, armed_q, mask_q;

  pwmflt_insync #(.STAGES(SYNC_STAGES), .ACTIVE_HIGH(ACTIVE_HIGH)) u_sync (
    .clk(clk), .rst(rst), .pin_i(fault_pin_i),
    .level_o(pin_lvl), .edge_o(pin_edge)
  );

  pwmflt_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .flag_i(flag_q), .level_i(pin_lvl), .rdata_o(reg_rdata_o),
    .mode_o(mode_q), .irq_en_o(irq_en_q), .safe_o(safe_q),
    .stat_rd_o(stat_rd), .stat_zero_o(stat_zero), .cfg_wr_o(cfg_wr)
  );

  pwmflt_flag u_flag (
    .clk(clk), .rst(rst), .mode_i(mode_q), .edge_i(pin_edge),
    .stat_rd_i(stat_rd), .stat_zero_i(stat_zero), .irq_en_i(irq_en_q),
    .flag_o(flag_q), .armed_o(armed_q), .irq_o(irq_o)
  );

  pwmflt_mask #(.NCH(NCH)) u_mask (
    .clk(clk), .rst(rst), .mode_i(mode_q), .edge_i(pin_edge),
    .level_i(pin_lvl), .flag_i(flag_q), .start_i(cycle_start_i),
    .raw_i(pwm_raw_i), .safe_i(safe_q), .mask_o(mask_q), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwmflt_chk.sv
module pwmflt_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode_q,
  input logic           irq_en_q,
  input logic           flag_q,
  input logic           armed_q,
  input logic           stat_zero,
  input logic           cfg_wr,
  input logic           pin_edge,
  input logic           mask_q,
  input logic           cycle_start_i,
  input logic [NCH-1:0] pwm_raw_i,
  input logic [NCH-1:0] safe_q,
  input logic [NCH-1:0] pwm_o,
  input logic           irq_o
);
  a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (pin_edge && mode_q != 2'b00) |=> flag_q);

  a_r3_masked_drives_safe: assert property (@(posedge clk) disable iff (rst)
    (mask_q && mode_q != 2'b00) |=> (pwm_o == $past(safe_q)));

  a_r4_irq_tracks_flag: assert property (@(posedge clk) disable iff (rst)
    (flag_q && irq_en_q) |=> irq_o);

  a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> ($past(armed_q) && $past(stat_zero)));

  a_r7_manual_holds_mask: assert property (@(posedge clk) disable iff (rst)
    (mask_q && flag_q && (mode_q == 2'b01 || mode_q == 2'b10) && !cfg_wr)
      |=> mask_q);

  a_r8_release_at_start: assert property (@(posedge clk) disable iff (rst)
    $fell(mask_q) |-> ($past(cycle_start_i) || $past(mode_q) == 2'b00));

  a_r10_off_passes_raw: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00) |=> (pwm_o == $past(pwm_raw_i)));
endmodule

bind pwmflt_top pwmflt_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .irq_en_q(irq_en_q),
  .flag_q(flag_q), .armed_q(armed_q), .stat_zero(stat_zero),
  .cfg_wr(cfg_wr), .pin_edge(pin_edge), .mask_q(mask_q),
  .cycle_start_i(cycle_start_i), .pwm_raw_i(pwm_raw_i), .safe_q(safe_q),
  .pwm_o(pwm_o), .irq_o(irq_o)
);

// File: tb/tb_pwmflt_top.sv
module tb_pwmflt_top;
  localparam int NCH = 4;
  localparam int DW  = 4;
  localparam logic [3:0] SAFE = 4'b1010;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           fault_pin = 1'b0;
  logic           cstart = 1'b0;
  logic [NCH-1:0] raw = '0;
  logic           rd = 1'b0, wr = 1'b0;
  logic [1:0]     addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic [NCH-1:0] pwm;
  logic           irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pwmflt_top #(.NCH(NCH), .SYNC_STAGES(2), .ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rst(rst), .fault_pin_i(fault_pin), .cycle_start_i(cstart),
    .pwm_raw_i(raw), .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  // {mode, pin, raw, expected pwm}, SAFE = 1010
  localparam int NV = 7;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 1'b0, 4'b0011, 4'b0011},
    {2'b00, 1'b1, 4'b0110, 4'b0110},
    {2'b01, 1'b0, 4'b1100, 4'b1100},
    {2'b01, 1'b1, 4'b0101, 4'b1010},
    {2'b10, 1'b1, 4'b1111, 4'b1010},
    {2'b11, 1'b1, 4'b0001, 4'b1010},
    {2'b11, 1'b0, 4'b1001, 4'b1001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fault_pin = 1'b0; cstart = 1'b0; rd = 1'b0; wr = 1'b0;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    cstart = 1'b1;
    @(negedge clk);
    cstart = 1'b0;
  endtask

  task automatic setup(input logic [1:0] mode, input logic ien);
    do_reset();
    reg_write(2'd2, SAFE);
    reg_write(2'd0, {1'b0, ien, mode});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d;

    // R11 reset state
    do_reset();
    raw = 4'b0110;
    idle(2);
    check("R11 pwm follows raw after reset", pwm, 4'b0110);
    check("R11 irq low after reset", irq, 1'b0);
    reg_read(2'd1, d); check("R11 status zero", d, 4'b0000);
    reg_read(2'd0, d); check("R11 config zero", d, 4'b0000);
    reg_read(2'd2, d); check("R11 safe zero", d, 4'b0000);

    // R1 mode decoding table
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][10:9], 1'b0);
      reg_read(2'd0, d);
      check("R1 config readback", d, {2'b00, VEC[i][10:9]});
      raw = VEC[i][7:4];
      fault_pin = VEC[i][8];
      idle(8);
      check("R1 mode table pwm", pwm, VEC[i][3:0]);
    end

    // R3 R4 R6 R2 R7: manual clear with pin left active
    setup(2'b01, 1'b1);
    raw = 4'b0101;
    fault_pin = 1'b1;
    idle(6);
    check("R3 pwm at safe", pwm, SAFE);
    check("R4 irq on flag", irq, 1'b1);
    reg_read(2'd1, d);
    check("R6 status flag and pin", d, 4'b0011);
    reg_write(2'd1, 4'b0000);
    idle(10);
    reg_read(2'd1, d);
    check("R2 steady level no re-set", d, 4'b0010);
    check("R4 irq drops with flag", irq, 1'b0);
    check("R7 masked until period start", pwm, SAFE);
    pulse_start();
    idle(2);
    check("R7 released at period start", pwm, 4'b0101);

    // R5 zero write without read; R7 start while flag set
    setup(2'b10, 1'b0);
    raw = 4'b0011;
    fault_pin = 1'b1;
    idle(6);
    reg_write(2'd1, 4'b0000);
    idle(2);
    pulse_start();
    idle(2);
    check("R7 start with flag set keeps mask", pwm, SAFE);
    reg_read(2'd1, d);
    check("R5 unarmed zero write ignored", d[0], 1'b1);
    reg_write(2'd1, 4'b0000);
    reg_read(2'd1, d);
    check("R5 armed zero write clears", d[0], 1'b0);

    // R8 automatic mode
    setup(2'b11, 1'b0);
    raw = 4'b1100;
    fault_pin = 1'b1;
    idle(6);
    pulse_start();
    idle(2);
    check("R8 start with pin active keeps mask", pwm, SAFE);
    fault_pin = 1'b0;
    idle(5);
    check("R8 no release without start", pwm, SAFE);
    pulse_start();
    idle(2);
    check("R8 released at start with pin low", pwm, 4'b1100);

    // R9 new edge between read and zero write
    setup(2'b01, 1'b0);
    fault_pin = 1'b1;
    idle(6);
    reg_read(2'd1, d);
    fault_pin = 1'b0;
    idle(5);
    fault_pin = 1'b1;
    idle(5);
    reg_write(2'd1, 4'b0000);
    reg_read(2'd1, d);
    check("R9 flag kept after new edge", d[0], 1'b1);
    reg_write(2'd1, 4'b0000);
    reg_read(2'd1, d);
    check("R9 fresh read then clear", d[0], 1'b0);

    // R10 mode off with interrupt enabled
    setup(2'b00, 1'b1);
    raw = 4'b1001;
    fault_pin = 1'b1;
    idle(6);
    reg_read(2'd1, d);
    check("R10 no flag in off mode", d, 4'b0010);
    check("R10 no irq in off mode", irq, 1'b0);
    check("R10 pass-through", pwm, 4'b1001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule